// File: doc/BRIEF.md
# Length-Triggered Word DMA Engine

This block copies blocks of 16-bit words between a large external main memory and one of two small local memories: an instruction store and a data store. Software programs it through a small 16-bit register file. It sets a 32-bit main memory byte address, a local word address, a control word and a gating register. Writing the byte count starts the transfer. From then on the engine runs on its own: it reports progress in a busy bit and reports the remaining count in the length register itself.

Every word that crosses between main memory and a local memory has its two bytes exchanged, in both directions. The engine moves one word per clock. Each memory port has a one-cycle read latency, so the engine overlaps the read of one word with the write of the previous one. Some requests are refused, and a refused request moves no data. A nonzero gating register suppresses a launch silently. An oversize count, or a copy out of the instruction store, raises a sticky error flag instead.

Register addresses on `cfg_addr`: 0 = main address high half, 1 = main address low half, 2 = local word address, 3 = control/status, 4 = gate (mask), 5 = length in bytes. Other addresses read as zero and ignore writes.

Top module: `dma_xfer_top`

## Requirements
- R1: The main memory byte address of the first word is {reg0, reg1}, and it rises by 2 per word. The local ports are word addressed and start at the value of reg2, rising by 1 per word.
- R2: A write to reg5 while idle starts a transfer of floor(count/2) words, one word per clock. A count of 0 or 1 moves nothing and never sets busy.
- R3: Control bit 2 (busy) reads 1 from the cycle after the launching write until the last word is written. For N words it stays high for exactly N+1 cycles.
- R4: Reg5 reads the count rounded down to even in the first busy cycle and 2 less in each following cycle. It reads 0 whenever the engine is idle, including after any refused launch.
- R5: Each word has its high and low bytes exchanged on the way from main memory to a local memory and on the way back.
- R6: Control bit 0 is the direction (1 = main memory into local, 0 = local out to main memory). Control bit 1 is the target (1 = instruction store, 0 = data store). Only the selected memory is written.
- R7: If reg4 is nonzero when reg5 is written, nothing moves, busy stays 0 and the error flag is unchanged.
- R8: A count above 0x4000 bytes moves nothing and sets the error flag. A count of exactly 0x4000 runs normally.
- R9: The selection instruction store with direction out (control bits 1:0 = 2'b10) moves nothing and sets the error flag.
- R10: The error flag reads on control bit 3. It stays set through any other register writes and launches until control (reg3) is written, which clears it.
- R11: While busy, every register write is ignored. This includes a write sampled on the final busy clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from cfg_addr) |
| main_en | output | 1 | Main memory access enable |
| main_we | output | 1 | Main memory write enable |
| main_addr | output | 32 | Main memory byte address |
| main_wdata | output | 16 | Main memory write data |
| main_rdata | input | 16 | Main memory read data, one cycle after the enable |
| imem_we | output | 1 | Instruction store write enable |
| imem_addr | output | LOC_AW | Instruction store word address |
| imem_wdata | output | 16 | Instruction store write data |
| dmem_en | output | 1 | Data store access enable |
| dmem_we | output | 1 | Data store write enable |
| dmem_addr | output | LOC_AW | Data store word address |
| dmem_wdata | output | 16 | Data store write data |
| dmem_rdata | input | 16 | Data store read data, one cycle after the enable |

## Verification
Two things meet in the same cycle at the end of a transfer: the final data write, and the release of busy together with the zeroing of the length. A register write sampled on that same edge is still ignored. The bench provokes this by presenting a write to reg1 exactly N cycles after the launch returns. It reads reg1 back unchanged, then repeats the write one cycle later and reads back the new value. The other overlap is a register write during the read/write overlap of a running copy. It is judged by reading back, once the copy ends, both the untouched register and the copied data, whose expected values the bench computes from the byte swap and the address arithmetic.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_MAIN_HI = 3'd0;
  localparam logic [REG_AW-1:0] RA_MAIN_LO = 3'd1;
  localparam logic [REG_AW-1:0] RA_LOCAL   = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd3;
  localparam logic [REG_AW-1:0] RA_GATE    = 3'd4;
  localparam logic [REG_AW-1:0] RA_LEN     = 3'd5;

  // control field positions
  localparam int unsigned CB_DIR_IN = 0;
  localparam int unsigned CB_INSTR  = 1;
  localparam int unsigned CB_BUSY   = 2;
  localparam int unsigned CB_ERR    = 3;

  function automatic logic [WORD_W-1:0] swap16(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [WORD_W-1:0] even_len(input logic [WORD_W-1:0] n);
    return {n[WORD_W-1:1], 1'b0};
  endfunction

  function automatic logic is_oversize(input logic [WORD_W-1:0] n,
                                       input logic [WORD_W-1:0] lim);
    return n > lim;
  endfunction

  function automatic logic is_refused(input logic [1:0] sel);
    return sel[CB_INSTR] && !sel[CB_DIR_IN];
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_xfer_pkg::*;
#(
  parameter int unsigned LOC_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] rem_len,
  input  logic              launch_err,
  output logic [WORD_W-1:0] main_hi,
  output logic [WORD_W-1:0] main_lo,
  output logic [LOC_AW-1:0] loc_word,
  output logic [WORD_W-1:0] gate,
  output logic [1:0]        sel,
  output logic              err_flag,
  output logic              len_wr,
  output logic              ctrl_wr,
  output logic [WORD_W-1:0] cfg_rdata
);

  logic wr_ok;
  assign wr_ok   = cfg_wr && !busy;
  assign len_wr  = wr_ok && (cfg_addr == RA_LEN);
  assign ctrl_wr = wr_ok && (cfg_addr == RA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_hi  <= '0;
      main_lo  <= '0;
      loc_word <= '0;
      gate     <= '0;
      sel      <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        RA_MAIN_HI: main_hi  <= cfg_wdata;
        RA_MAIN_LO: main_lo  <= cfg_wdata;
        RA_LOCAL:   loc_word <= cfg_wdata[LOC_AW-1:0];
        RA_CTRL:    sel      <= cfg_wdata[1:0];
        RA_GATE:    gate     <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_flag <= 1'b0;
    else if (launch_err) err_flag <= 1'b1;
    else if (ctrl_wr)    err_flag <= 1'b0;
  end

  logic [WORD_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view           = '0;
    ctrl_view[1:0]      = sel;
    ctrl_view[CB_BUSY]  = busy;
    ctrl_view[CB_ERR]   = err_flag;
  end

  always_comb begin
    case (cfg_addr)
      RA_MAIN_HI: cfg_rdata = main_hi;
      RA_MAIN_LO: cfg_rdata = main_lo;
      RA_LOCAL:   cfg_rdata = WORD_W'(loc_word);
      RA_CTRL:    cfg_rdata = ctrl_view;
      RA_GATE:    cfg_rdata = gate;
      RA_LEN:     cfg_rdata = rem_len;
      default:    cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_launch.sv
module dma_launch
  import dma_xfer_pkg::*;
#(
  parameter logic [15:0] MAX_LEN = 16'h4000
) (
  input  logic              len_wr,
  input  logic [WORD_W-1:0] len_val,
  input  logic [WORD_W-1:0] gate,
  input  logic [1:0]        sel,
  output logic              launch_ok,
  output logic              launch_masked,
  output logic              launch_err
);

  logic open_gate, bad_req, empty;
  assign open_gate     = (gate == '0);
  assign bad_req       = is_oversize(len_val, MAX_LEN) || is_refused(sel);
  assign empty         = (even_len(len_val) == '0);

  assign launch_masked = len_wr && !open_gate;
  assign launch_err    = len_wr && open_gate && bad_req;
  assign launch_ok     = len_wr && open_gate && !bad_req && !empty;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_xfer_pkg::*;
#(
  parameter int unsigned LOC_AW  = 12,
  parameter int unsigned MAIN_AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_ok,
  input  logic [MAIN_AW-1:0] start_main,
  input  logic [LOC_AW-1:0]  start_loc,
  input  logic [WORD_W-1:0]  len_val,
  input  logic [1:0]         sel,
  output logic               busy,
  output logic [WORD_W-1:0]  rem_len,
  output logic               issue_fire,
  output logic               wr_fire,
  output logic               xfer_done,
  output logic               main_en,
  output logic               main_we,
  output logic [MAIN_AW-1:0] main_addr,
  output logic [WORD_W-1:0]  main_wdata,
  input  logic [WORD_W-1:0]  main_rdata,
  output logic               imem_we,
  output logic [LOC_AW-1:0]  imem_addr,
  output logic [WORD_W-1:0]  imem_wdata,
  output logic               dmem_en,
  output logic               dmem_we,
  output logic [LOC_AW-1:0]  dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  input  logic [WORD_W-1:0]  dmem_rdata
);

  localparam logic [MAIN_AW-1:0] MAIN_STEP = MAIN_AW'(2);
  localparam logic [LOC_AW-1:0]  LOC_STEP  = LOC_AW'(1);
  localparam logic [WORD_W-1:0]  LEN_STEP  = WORD_W'(2);

  logic [MAIN_AW-1:0] main_ptr, pend_main;
  logic [LOC_AW-1:0]  loc_ptr, pend_loc;

  assign issue_fire = busy && (rem_len != '0);
  assign xfer_done  = busy && (rem_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rem_len   <= '0;
      main_ptr  <= '0;
      loc_ptr   <= '0;
      wr_fire   <= 1'b0;
      pend_main <= '0;
      pend_loc  <= '0;
    end else begin
      wr_fire <= issue_fire;
      if (issue_fire) begin
        pend_main <= main_ptr;
        pend_loc  <= loc_ptr;
      end
      if (launch_ok) begin
        busy     <= 1'b1;
        rem_len  <= even_len(len_val);
        main_ptr <= start_main;
        loc_ptr  <= start_loc;
      end else if (issue_fire) begin
        rem_len  <= rem_len - LEN_STEP;
        main_ptr <= main_ptr + MAIN_STEP;
        loc_ptr  <= loc_ptr + LOC_STEP;
      end else if (xfer_done) begin
        busy <= 1'b0;
      end
    end
  end

  logic inbound, to_instr;
  assign inbound  = sel[CB_DIR_IN];
  assign to_instr = sel[CB_INSTR];

  // main memory side: read source when inbound, write sink when outbound
  assign main_we    = wr_fire && !inbound;
  assign main_en    = (issue_fire && inbound) || main_we;
  assign main_addr  = main_we ? pend_main : main_ptr;
  assign main_wdata = swap16(dmem_rdata);

  // data store: source when outbound, sink when inbound to it
  assign dmem_we    = wr_fire && inbound && !to_instr;
  assign dmem_en    = (issue_fire && !inbound) || dmem_we;
  assign dmem_addr  = dmem_we ? pend_loc : loc_ptr;
  assign dmem_wdata = swap16(main_rdata);

  // instruction store: sink only
  assign imem_we    = wr_fire && inbound && to_instr;
  assign imem_addr  = pend_loc;
  assign imem_wdata = swap16(main_rdata);

endmodule

// File: rtl/dma_xfer_top.sv
module dma_xfer_top
  import dma_xfer_pkg::*;
#(
  parameter int unsigned LOC_AW  = 12,
  parameter logic [15:0] MAX_LEN = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic              main_en,
  output logic              main_we,
  output logic [31:0]       main_addr,
  output logic [15:0]       main_wdata,
  input  logic [15:0]       main_rdata,
  output logic              imem_we,
  output logic [LOC_AW-1:0] imem_addr,
  output logic [15:0]       imem_wdata,
  output logic              dmem_en,
  output logic              dmem_we,
  output logic [LOC_AW-1:0] dmem_addr,
  output logic [15:0]       dmem_wdata,
  input  logic [15:0]       dmem_rdata
);

  localparam int unsigned MAIN_AW = 2 * WORD_W;

  logic [WORD_W-1:0] main_hi, main_lo, gate, rem_len;
  logic [LOC_AW-1:0] loc_word;
  logic [1:0]        sel;
  logic              err_flag, len_wr, ctrl_wr, busy;
  logic              launch_ok, launch_masked, launch_err;
  logic              issue_fire, wr_fire, xfer_done;

  dma_regs #(.LOC_AW(LOC_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .rem_len(rem_len),
    .launch_err(launch_err), .main_hi(main_hi), .main_lo(main_lo),
    .loc_word(loc_word), .gate(gate), .sel(sel), .err_flag(err_flag),
    .len_wr(len_wr), .ctrl_wr(ctrl_wr), .cfg_rdata(cfg_rdata)
  );

  dma_launch #(.MAX_LEN(MAX_LEN)) u_launch (
    .len_wr(len_wr), .len_val(cfg_wdata), .gate(gate), .sel(sel),
    .launch_ok(launch_ok), .launch_masked(launch_masked),
    .launch_err(launch_err)
  );

  dma_mover #(.LOC_AW(LOC_AW), .MAIN_AW(MAIN_AW)) u_mover (
    .clk(clk), .rst_n(rst_n), .launch_ok(launch_ok),
    .start_main({main_hi, main_lo}), .start_loc(loc_word),
    .len_val(cfg_wdata), .sel(sel), .busy(busy), .rem_len(rem_len),
    .issue_fire(issue_fire), .wr_fire(wr_fire), .xfer_done(xfer_done),
    .main_en(main_en), .main_we(main_we), .main_addr(main_addr),
    .main_wdata(main_wdata), .main_rdata(main_rdata),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [2:0]  cfg_addr,
  input logic        busy,
  input logic        err_flag,
  input logic [15:0] rem_len,
  input logic [15:0] main_hi,
  input logic [1:0]  sel,
  input logic        launch_ok,
  input logic        launch_masked,
  input logic        launch_err,
  input logic        issue_fire,
  input logic        wr_fire,
  input logic        xfer_done,
  input logic        imem_we,
  input logic        dmem_we,
  input logic        main_we
);

  assert_busy_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |=> busy);

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> wr_fire);

  assert_live_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_fire) |-> (rem_len != 16'd0));

  assert_len_zero_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!busy && rem_len == 16'd0));

  assert_one_sink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_we, dmem_we, main_we}));

  assert_gate_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_masked |=> (!busy && rem_len == 16'd0 && $stable(err_flag)));

  assert_err_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_err |=> (err_flag && !busy));

  assert_instr_inbound_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> (sel == 2'b11));

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !busy && cfg_addr == 3'd3) |=> !err_flag);

  assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> $stable(main_hi));

endmodule

bind dma_xfer_top dma_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .busy(busy), .err_flag(err_flag), .rem_len(rem_len), .main_hi(main_hi),
  .sel(sel), .launch_ok(launch_ok), .launch_masked(launch_masked),
  .launch_err(launch_err), .issue_fire(issue_fire), .wr_fire(wr_fire),
  .xfer_done(xfer_done), .imem_we(imem_we), .dmem_we(dmem_we),
  .main_we(main_we)
);

// File: tb/tb_dma_xfer_top.sv
`timescale 1ns/1ps
module tb_dma_xfer_top;

  localparam int LOC_AW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        main_en, main_we, imem_we, dmem_en, dmem_we;
  logic [31:0] main_addr;
  logic [15:0] main_wdata, imem_wdata, dmem_wdata;
  logic [15:0] main_rdata = '0, dmem_rdata = '0;
  logic [LOC_AW-1:0] imem_addr, dmem_addr;

  always #2.5 clk = ~clk;

  dma_xfer_top #(.LOC_AW(LOC_AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .main_en(main_en),
    .main_we(main_we), .main_addr(main_addr), .main_wdata(main_wdata),
    .main_rdata(main_rdata), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .dmem_en(dmem_en), .dmem_we(dmem_we),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  logic [15:0] mmem [256];
  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  always @(posedge clk) begin
    if (main_en && !main_we) main_rdata <= mmem[main_addr[8:1]];
    if (main_we) mmem[main_addr[8:1]] <= main_wdata;
    if (dmem_en && !dmem_we) dmem_rdata <= dmem[dmem_addr[7:0]];
    if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    if (imem_we) imem[imem_addr[7:0]] <= imem_wdata;
  end

  int total = 0;
  int fails = 0;

  function automatic logic [15:0] pm(input int i);
    return {8'(i) ^ 8'hA5, 8'(i) + 8'h11};
  endfunction
  function automatic logic [15:0] pi(input int i);
    return {8'(i) + 8'h40, 8'(i) ^ 8'h3C};
  endfunction
  function automatic logic [15:0] pd(input int i);
    return {8'(i) ^ 8'h5A, 8'(i) + 8'h77};
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) begin
      mmem[i] = pm(i); imem[i] = pi(i); dmem[i] = pd(i);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic count_busy(output int cnt);
    logic [15:0] c;
    cnt = 0;
    forever begin
      rd(3'd3, c);
      if (!c[2] || cnt > 9000) break;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic run_xfer(input logic [1:0] sel, input logic [15:0] hi,
                          input logic [15:0] lo, input logic [15:0] loc,
                          input logic [15:0] len);
    logic [15:0] v;
    int cnt, n, mb, ex, ac;
    n = len / 2;
    mb = lo / 2;
    fill();
    wr(3'd3, {14'd0, sel});
    wr(3'd4, 16'd0);
    wr(3'd0, hi);
    wr(3'd1, lo);
    wr(3'd2, loc);
    wr(3'd5, len);
    if (n > 0) begin
      chk(main_addr == {hi, lo}, "R1 start main address", main_addr, {hi, lo});
      rd(3'd5, v);
      chk(v == (len & 16'hFFFE), "R4 length in first busy cycle", v, len & 16'hFFFE);
    end
    count_busy(cnt);
    chk(cnt == ((n > 0) ? n + 1 : 0), "R3 busy cycles", cnt, (n > 0) ? n + 1 : 0);
    rd(3'd5, v);
    chk(v == 0, "R4 length zero at end", v, 0);
    @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      if (sel == 2'b00) begin
        ac = mmem[(mb + k) & 255];
        ex = (k < n) ? sw(pd((loc + k) & 255)) : pm((mb + k) & 255);
        chk(ac == ex, "R5 R6 outbound word", ac, ex);
      end else if (sel == 2'b01) begin
        ac = dmem[(loc + k) & 255];
        ex = (k < n) ? sw(pm((mb + k) & 255)) : pd((loc + k) & 255);
        chk(ac == ex, "R5 R6 inbound data word", ac, ex);
        ac = imem[(loc + k) & 255];
        chk(ac == pi((loc + k) & 255), "R6 other store untouched", ac, pi((loc + k) & 255));
      end else begin
        ac = imem[(loc + k) & 255];
        ex = (k < n) ? sw(pm((mb + k) & 255)) : pi((loc + k) & 255);
        chk(ac == ex, "R5 R6 inbound instr word", ac, ex);
        ac = dmem[(loc + k) & 255];
        chk(ac == pd((loc + k) & 255), "R6 other store untouched", ac, pd((loc + k) & 255));
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int cnt;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R4 reset register value", v, 0);
    end

    // sweep direction/target and length
    for (int s = 0; s < 3; s++) begin
      for (int li = 0; li < 5; li++) begin
        logic [1:0]  sel;
        logic [15:0] len;
        sel = (s == 0) ? 2'b01 : (s == 1) ? 2'b11 : 2'b00;
        len = (li == 0) ? 16'd2 : (li == 1) ? 16'd4 : (li == 2) ? 16'd10 :
              (li == 3) ? 16'd32 : 16'd62;
        run_xfer(sel, 16'h1200 + 16'(s * 16 + li), 16'(2 * (li * 37 + s * 11)),
                 16'(li * 29 + s * 5), len);
      end
    end

    // odd and tiny counts
    run_xfer(2'b01, 16'h0, 16'h0040, 16'd7, 16'd7);
    run_xfer(2'b01, 16'h0, 16'h0040, 16'd7, 16'd1);
    run_xfer(2'b00, 16'h0, 16'h0020, 16'd3, 16'd0);

    // gate register suppresses the launch
    fill();
    wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0100);
    wr(3'd2, 16'd9);
    wr(3'd5, 16'd8);
    rd(3'd3, v);
    chk(v[2] == 0, "R7 gated launch stays idle", v[2], 0);
    chk(v[3] == 0, "R7 gated launch raises no error", v[3], 0);
    rd(3'd5, v);
    chk(v == 0, "R7 gated length reads zero", v, 0);
    repeat (6) @(negedge clk);
    chk(dmem[9] == pd(9), "R7 gated data untouched", dmem[9], pd(9));
    wr(3'd4, 16'h0000);

    // oversize count
    wr(3'd5, 16'h4002);
    rd(3'd3, v);
    chk(v[3] == 1 && v[2] == 0, "R8 oversize sets error, stays idle", v, 16'h0009);
    rd(3'd5, v);
    chk(v == 0, "R8 oversize length reads zero", v, 0);
    repeat (6) @(negedge clk);
    chk(dmem[9] == pd(9), "R8 oversize moves nothing", dmem[9], pd(9));

    // error persists through other writes and a gated launch
    wr(3'd0, 16'h00AA);
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'd4);
    wr(3'd4, 16'h0000);
    rd(3'd3, v);
    chk(v[3] == 1, "R10 error sticky across other writes", v[3], 1);
    wr(3'd3, 16'h0001);
    rd(3'd3, v);
    chk(v[3] == 0, "R10 control write clears error", v[3], 0);

    // refused direction
    fill();
    wr(3'd3, 16'h0002);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'd4);
    wr(3'd5, 16'd8);
    rd(3'd3, v);
    chk(v[3] == 1 && v[2] == 0, "R9 refused selection sets error", v, 16'h000A);
    repeat (6) @(negedge clk);
    chk(mmem[8] == pm(8), "R9 refused moves nothing", mmem[8], pm(8));
    wr(3'd3, 16'h0001);

    // exactly the limit runs
    wr(3'd5, 16'h4000);
    count_busy(cnt);
    chk(cnt == 8193, "R8 limit count runs full length", cnt, 8193);
    rd(3'd3, v);
    chk(v[3] == 0, "R8 limit count raises no error", v[3], 0);

    // writes during a transfer, including on the final busy edge
    fill();
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0100);
    wr(3'd2, 16'd20);
    wr(3'd5, 16'd8);
    wr(3'd0, 16'h7777);
    wr(3'd3, 16'h0002);
    repeat (2) @(negedge clk);
    rd(3'd3, v);
    chk(v[2] == 1, "R11 still busy on final cycle", v[2], 1);
    wr(3'd1, 16'hBEEF);
    rd(3'd1, v);
    chk(v == 16'h0100, "R11 write on final busy edge ignored", v, 16'h0100);
    rd(3'd0, v);
    chk(v == 16'h0000, "R11 write mid-transfer ignored", v, 0);
    rd(3'd3, v);
    chk(v[1:0] == 2'b01, "R11 control write while busy ignored", v[1:0], 2'b01);
    wr(3'd1, 16'hBEEF);
    rd(3'd1, v);
    chk(v == 16'hBEEF, "R11 write after busy accepted", v, 16'hBEEF);
    for (int k = 0; k < 4; k++)
      chk(dmem[20 + k] == sw(pm(128 + k)), "R5 data beside register writes",
          dmem[20 + k], sw(pm(128 + k)));

    finish_run();
  end

endmodule